// File: doc/BRIEF.md
# End-of-Write Status Read Mux

This block sits on the read path of a memory whose writes are self-timed. When no internal programming cycle is running, a read returns the byte that the array supplies. While the programming controller reports that it is busy, every read returns a status word instead. The top bit of that word is the inverted top bit of the byte written last. The next bit changes value on every successive read. A host can therefore find out that the cycle has ended in either of two ways: it can compare the top bit with its own data, or it can read twice and look for a bit that stops changing.

The block is clocked. The chip-select and output-enable strobes are active low and arrive as synchronous inputs. A read lasts as long as both strobes stay low, and one such interval counts as one read, however many clock cycles it spans. The output data and the bus-drive enable are combinational from the strobes and from a small amount of state, so a read shows its value in the first cycle of the strobe.

Top module: `eow_status_mux`

## Requirements
- R1: `drive_en` is high exactly when `chip_en_n` and `out_en_n` are both low. Whenever either one is high, `drive_en` is low and `rd_data` is all zeros.
- R2: During a read while `busy` is low, `rd_data` equals `array_data`.
- R3: During a read while `busy` is high, bit 7 of `rd_data` is the inverse of bit 7 of `last_wr_data`.
- R4: During reads while `busy` is high, bit 6 of `rd_data` takes the opposite value from the one that the previous busy read returned, and it holds steady for the whole of one read, even one that lasts several cycles.
- R5: During a read while `busy` is high, bits 5 to 0 of `rd_data` are zero.
- R6: Reads made while `busy` is low do not advance the toggle state. The first busy read after such reads returns the inverse of the bit 6 that the last busy read returned.
- R7: After reset the toggle state is cleared, so the first busy read returns bit 6 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_en_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Output enable, active low |
| busy | input | 1 | High while the internal programming cycle runs |
| last_wr_data | input | DATA_W | Byte captured by the most recent write |
| array_data | input | DATA_W | Byte read from the storage array |
| rd_data | output | DATA_W | Data returned to the host, zero when the bus is not driven |
| drive_en | output | 1 | Enables the bus drivers; low means high impedance |

## Verification
Reads while idle use several array bytes, which shows that true data passes through unchanged and that no status bits leak into it. Busy reads use written bytes with bit 7 both set and clear, which distinguishes a real inversion from a constant. Runs of single-cycle and multi-cycle busy reads, interleaved with idle reads and with every combination of the strobes, distinguish a toggle that advances per read from one that advances per clock, and a toggle that freezes when the cycle ends from one that keeps running.

// File: rtl/eow_status_mux.sv
module eow_status_mux #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en_n,
  input  logic              out_en_n,
  input  logic              busy,
  input  logic [DATA_W-1:0] last_wr_data,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              drive_en
);

  localparam int POLL_B = DATA_W - 1;
  localparam int TOG_B  = DATA_W - 2;

  logic sel, sel_q, rd_start, tog_q, tog_view;
  logic [DATA_W-1:0] status;

  assign sel      = ~chip_en_n & ~out_en_n;
  assign rd_start = sel & ~sel_q;
  assign tog_view = tog_q ^ (rd_start & busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      sel_q <= sel;
      if (rd_start && busy) tog_q <= ~tog_q;
    end
  end

  always_comb begin
    status         = '0;
    status[POLL_B] = ~last_wr_data[POLL_B];
    status[TOG_B]  = tog_view;
  end

  assign drive_en = sel;
  assign rd_data  = !sel ? '0 : (busy ? status : array_data);

  p_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en_n || out_en_n) |-> (!drive_en && rd_data == '0));

  p_true_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && !busy) |-> (rd_data == array_data));

  p_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && busy) |-> (rd_data[POLL_B] != last_wr_data[POLL_B]));

  p_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && busy && $past(drive_en) && $past(busy)) |-> $stable(rd_data[TOG_B]));

  p_resv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && busy) |-> (rd_data[TOG_B-1:0] == '0));

endmodule

// File: tb/eow_status_mux_bench.sv
module eow_status_mux_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en_n = 1'b1, out_en_n = 1'b1, busy = 1'b0;
  logic [7:0] last_wr_data = '0, array_data = '0;
  logic [7:0] rd_data;
  logic drive_en;
  int checks = 0, failures = 0;
  logic exp_tog = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  eow_status_mux #(.DATA_W(8)) u_eow_status_mux (
    .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
    .busy(busy), .last_wr_data(last_wr_data), .array_data(array_data),
    .rd_data(rd_data), .drive_en(drive_en));

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_cycles(input int n, input string req, input logic [7:0] exp);
    @(negedge clk); chip_en_n = 1'b0; out_en_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      #1 check(req, {drive_en, rd_data}, {1'b1, exp});
      if (i < n - 1) @(negedge clk);
    end
    @(negedge clk); chip_en_n = 1'b1; out_en_n = 1'b1;
    #1 check("R1 release", {drive_en, rd_data}, 9'h000);
  endtask

  task automatic busy_read(input int n, input string req);
    exp_tog = ~exp_tog;
    read_cycles(n, req, {~last_wr_data[7], exp_tog, 6'b0});
  endtask

  task automatic t_reset;
    #1 check("R1 reset", {drive_en, rd_data}, 9'h000);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_hiz;
    array_data = 8'hA5;
    @(negedge clk); chip_en_n = 1'b0; out_en_n = 1'b1;
    #1 check("R1 oe high", {drive_en, rd_data}, 9'h000);
    @(negedge clk); chip_en_n = 1'b1; out_en_n = 1'b0;
    #1 check("R1 ce high", {drive_en, rd_data}, 9'h000);
    @(negedge clk); busy = 1'b1;
    #1 check("R1 busy no read", {drive_en, rd_data}, 9'h000);
    @(negedge clk); out_en_n = 1'b1; busy = 1'b0;
  endtask

  task automatic t_first_after_reset;
    busy = 1'b1; last_wr_data = 8'h00;
    read_cycles(1, "R7 first busy read", 8'hC0);
    exp_tog = 1'b1;
    busy = 1'b0;
  endtask

  task automatic t_true_data;
    array_data = 8'h3C; read_cycles(2, "R2 true 3C", 8'h3C);
    array_data = 8'hFF; read_cycles(1, "R2 true FF", 8'hFF);
    array_data = 8'h81; read_cycles(3, "R2 true 81", 8'h81);
  endtask

  task automatic t_poll_and_toggle;
    busy = 1'b1;
    last_wr_data = 8'h7F; busy_read(1, "R3 R4 R5 bit7 clear");
    last_wr_data = 8'h80; busy_read(1, "R3 R4 R5 bit7 set");
    busy_read(4, "R4 long read steady");
    last_wr_data = 8'h5A; busy_read(2, "R3 R4 R5 mixed");
    busy = 1'b0;
  endtask

  task automatic t_freeze;
    array_data = 8'h42;
    read_cycles(1, "R6 idle read", 8'h42);
    read_cycles(3, "R6 idle read long", 8'h42);
    repeat (5) @(negedge clk);
    busy = 1'b1; last_wr_data = 8'hE1;
    busy_read(1, "R6 resume toggle");
    busy_read(1, "R4 after resume");
    busy = 1'b0;
  endtask

  initial begin
    t_reset();
    t_hiz();
    t_first_after_reset();
    t_true_data();
    t_poll_and_toggle();
    t_freeze();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule